// File: doc/BRIEF.md
# Prescaled Up/Down Interval Timer

This block is a general-purpose interval timer for a host processor. It sits on a simple register bus that completes a write on the clock edge where select and write are both high, and returns read data combinationally in the same cycle. A programmable prescaler divides the clock into count ticks. A counter of parameterised width (16 or 32 bits) steps up or down on each tick. When the counter reaches its terminal value it raises a sticky status flag. It then either reloads itself and keeps going, or stops.

Software controls the counter in three separate ways. A stop clears the run flag, and the next run re-arms the counter from its preload value. A halt freezes the counter and picks up again from the held value. A forced reload copies the preload value into the counter, but only while the timer runs. A self-clearing soft-reset flag returns every register to its power-on value after a fixed number of cycles. The interrupt line is the status flag gated by an interrupt-enable flag.

Top module: `gp_tick_timer`

## Requirements
- R1: After the reset input is asserted, every register reads 0 and `irq` is low.
- R2: The prescale field, control word bits 31:16, gives one count tick every (prescale+1) clocks while the timer runs. The prescaler restarts from zero whenever the counter is loaded from preload.
- R3: With the direction flag (control bit 1) clear, each tick decrements the counter and the terminal value is 0. With it set, each tick increments the counter and the terminal value is all ones. A tick that finds the counter at its terminal value is the terminal event.
- R4: With the auto-restart flag (control bit 2) set, a terminal event loads the preload value into the counter and the run flag stays set.
- R5: With auto-restart clear, a terminal event clears the run flag (control bit 4) and the counter holds its terminal value.
- R6: Clearing the run flag freezes the counter. The clock after the run flag goes from 0 to 1, the counter is loaded from preload.
- R7: While the halt flag (control bit 6) is set, the counter and prescaler hold. Clearing halt resumes counting from the held value, with no reload.
- R8: Setting the reload flag (control bit 5) while the run flag is set loads preload into the counter on the next clock. While stopped, the request has no effect on the counter. The flag reads 0 again one clock after it is taken.
- R9: While the enable flag (control bit 0) is clear, the counter, the prescaler, the run-edge detection and the reload flag are all frozen. Setting enable again resumes counting without a reload.
- R10: The terminal event sets status bit 0. Writing 1 to status bit 0 clears it, and a set in the same cycle wins. `irq` is high exactly when status bit 0 and interrupt-enable bit 0 are both 1.
- R11: Writing 1 to control bit 3 starts a soft reset. The bit reads 1 for RST_CYCLES clocks, bus writes are ignored during that time, and then every register returns to 0.
- R12: Count and preload can be written at any time, and only the low CNT_W bits are kept. A count write overrides the timer's own update in the same cycle.
- R13: The register indices on `bus_addr` are: 0 count, 1 preload, 2 status, 3 interrupt enable, 4 control. Any other index reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, taken at the clock edge when `bus_sel` is high |
| bus_addr | input | ADDR_W | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that no bus write lands while a soft reset is in progress, and they check this by construction of the write gate. They also assume that a control write in the same cycle as a terminal event or a reload clear takes precedence, so those checks are disabled when a control write is present. The stimulus holds every bus value for a whole clock, changing it only at the falling edge. It never issues two writes in consecutive cycles, so each event lands on a known edge. The prescale and preload values are kept small, so every terminal event and wrap occurs within a few dozen cycles and the reference model sees each one.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned PSC_W  = 16;

  // register indices
  localparam int unsigned IDX_COUNT   = 0;
  localparam int unsigned IDX_PRELOAD = 1;
  localparam int unsigned IDX_STATUS  = 2;
  localparam int unsigned IDX_INTEN   = 3;
  localparam int unsigned IDX_CTRL    = 4;

  // control word bit positions
  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_UP     = 1;
  localparam int unsigned B_AUTO   = 2;
  localparam int unsigned B_SRST   = 3;
  localparam int unsigned B_START  = 4;
  localparam int unsigned B_RELOAD = 5;
  localparam int unsigned B_HALT   = 6;
  localparam int unsigned PSC_LSB  = 16;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic             halt;
    logic             reload;
    logic             start;
    logic             srst;
    logic             auto_rst;
    logic             up;
    logic             en;
  } ctrl_t;

  function automatic ctrl_t ctrl_decode(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c.psc      = w[PSC_LSB +: PSC_W];
    c.halt     = w[B_HALT];
    c.reload   = w[B_RELOAD];
    c.start    = w[B_START];
    c.srst     = w[B_SRST];
    c.auto_rst = w[B_AUTO];
    c.up       = w[B_UP];
    c.en       = w[B_EN];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_encode(input ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[PSC_LSB +: PSC_W] = c.psc;
    w[B_HALT]   = c.halt;
    w[B_RELOAD] = c.reload;
    w[B_START]  = c.start;
    w[B_SRST]   = c.srst;
    w[B_AUTO]   = c.auto_rst;
    w[B_UP]     = c.up;
    w[B_EN]     = c.en;
    return w;
  endfunction

endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc_val,
  output logic             tick
);

  logic [PSC_W-1:0] cnt_q;

  function automatic logic at_limit(input logic [PSC_W-1:0] c, input logic [PSC_W-1:0] lim);
    return c == lim;
  endfunction

  assign tick = run && !restart && at_limit(cnt_q, psc_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (por || restart) cnt_q <= '0;
    else if (run) begin
      if (tick) cnt_q <= '0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

  // R2
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por,
  input  logic             tick,
  input  logic             up,
  input  logic             auto_rst,
  input  logic             load,
  input  logic [CNT_W-1:0] preload,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] count,
  output logic             term_evt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             at_term;

  function automatic logic [CNT_W-1:0] term_value(input logic dir_up);
    return dir_up ? {CNT_W{1'b1}} : {CNT_W{1'b0}};
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c, input logic dir_up);
    return dir_up ? c + 1'b1 : c - 1'b1;
  endfunction

  assign at_term  = (cnt_q == term_value(up));
  assign term_evt = tick && at_term;
  assign count    = cnt_q;

  always_comb begin
    cnt_nxt = cnt_q;
    if (wr_en)       cnt_nxt = wr_val;
    else if (load)   cnt_nxt = preload;
    else if (tick) begin
      if (at_term) begin
        if (auto_rst) cnt_nxt = preload;
      end else begin
        cnt_nxt = step(cnt_q, up);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (por) cnt_q <= '0;
    else          cnt_q <= cnt_nxt;
  end

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !term_evt && !wr_en && up) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !term_evt && !wr_en && !up) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R4
  auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_evt && auto_rst && !wr_en) |=> (cnt_q == $past(preload)));

endmodule

// File: rtl/gpt_softrst.sv
module gpt_softrst #(
  parameter int unsigned RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic done
);

  localparam int unsigned CW = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done = go && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!go || done) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/gp_tick_timer.sv
module gp_tick_timer
  import gpt_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned RST_CYCLES = 8,
  parameter int unsigned ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] preload_q;
  logic [CNT_W-1:0] count_w;
  logic             sts_q;
  logic             ien_q;
  logic             start_d_q;

  // named internal events
  logic wr_any, wr_cnt, wr_pre, wr_sts, wr_ien, wr_ctl;
  logic por, load_evt, run, tick, term_evt;

  assign wr_any = bus_sel && bus_wr && !ctrl_q.srst;
  assign wr_cnt = wr_any && (bus_addr == ADDR_W'(IDX_COUNT));
  assign wr_pre = wr_any && (bus_addr == ADDR_W'(IDX_PRELOAD));
  assign wr_sts = wr_any && (bus_addr == ADDR_W'(IDX_STATUS));
  assign wr_ien = wr_any && (bus_addr == ADDR_W'(IDX_INTEN));
  assign wr_ctl = wr_any && (bus_addr == ADDR_W'(IDX_CTRL));

  assign load_evt = ctrl_q.en && !ctrl_q.srst && ctrl_q.start &&
                    (!start_d_q || ctrl_q.reload);
  assign run      = ctrl_q.en && !ctrl_q.srst && ctrl_q.start && !ctrl_q.halt;

  gpt_softrst #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (ctrl_q.srst),
    .done (por)
  );

  gpt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .por    (por),
    .run    (run),
    .restart(load_evt),
    .psc_val(ctrl_q.psc),
    .tick   (tick)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .por     (por),
    .tick    (tick),
    .up      (ctrl_q.up),
    .auto_rst(ctrl_q.auto_rst),
    .load    (load_evt),
    .preload (preload_q),
    .wr_en   (wr_cnt),
    .wr_val  (bus_wdata[CNT_W-1:0]),
    .count   (count_w),
    .term_evt(term_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (por)    ctrl_q <= '0;
    else if (wr_ctl) ctrl_q <= ctrl_decode(bus_wdata);
    else begin
      if (term_evt && !ctrl_q.auto_rst)  ctrl_q.start  <= 1'b0;
      if (ctrl_q.en && !ctrl_q.srst)     ctrl_q.reload <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           start_d_q <= 1'b0;
    else if (por)                         start_d_q <= 1'b0;
    else if (ctrl_q.en && !ctrl_q.srst)   start_d_q <= ctrl_q.start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      preload_q <= '0;
    else if (por)    preload_q <= '0;
    else if (wr_pre) preload_q <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       sts_q <= 1'b0;
    else if (por)                     sts_q <= 1'b0;
    else if (term_evt)                sts_q <= 1'b1;
    else if (wr_sts && bus_wdata[0])  sts_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= 1'b0;
    else if (por)    ien_q <= 1'b0;
    else if (wr_ien) ien_q <= bus_wdata[0];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == ADDR_W'(IDX_COUNT))        bus_rdata[CNT_W-1:0] = count_w;
      else if (bus_addr == ADDR_W'(IDX_PRELOAD)) bus_rdata[CNT_W-1:0] = preload_q;
      else if (bus_addr == ADDR_W'(IDX_STATUS))  bus_rdata[0] = sts_q;
      else if (bus_addr == ADDR_W'(IDX_INTEN))   bus_rdata[0] = ien_q;
      else if (bus_addr == ADDR_W'(IDX_CTRL))    bus_rdata = ctrl_encode(ctrl_q);
    end
  end

  assign irq = sts_q && ien_q;

  // R5
  stop_at_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_evt && !ctrl_q.auto_rst && !wr_ctl) |=> !ctrl_q.start);

  // R10
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt |=> sts_q);

  // R8
  reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.reload && ctrl_q.en && !ctrl_q.srst && !wr_ctl) |=> !ctrl_q.reload);

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.halt && !load_evt && !wr_cnt) |=> $stable(count_w));

  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por |=> (count_w == '0 && ctrl_q == '0 && !sts_q && !ien_q));

  // R6
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.en && !ctrl_q.srst && ctrl_q.start && !start_d_q && !wr_cnt)
      |=> (count_w == $past(preload_q)));

endmodule

// File: tb/gp_tick_timer_tb_top.sv
module gp_tick_timer_tb_top;

  localparam int unsigned CNT_W = 16;
  localparam int unsigned RSTC  = 8;
  localparam logic [31:0] MASK  = (CNT_W == 32) ? 32'hFFFF_FFFF : ((32'd1 << CNT_W) - 32'd1);

  localparam logic [31:0] C_EN = 32'h01, C_UP = 32'h02, C_AR = 32'h04, C_SR = 32'h08;
  localparam logic [31:0] C_ST = 32'h10, C_RL = 32'h20, C_HT = 32'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  gp_tick_timer #(.CNT_W(CNT_W), .RST_CYCLES(RSTC), .ADDR_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_count, m_pre, m_pcnt, m_psc;
  bit m_sts, m_ien, m_en, m_up, m_ar, m_srst, m_start, m_reload, m_halt, m_startd;
  int m_scnt;

  function automatic logic [31:0] m_ctrl_word();
    return (m_psc << 16) | (32'(m_halt) << 6) | (32'(m_reload) << 5) | (32'(m_start) << 4) |
           (32'(m_srst) << 3) | (32'(m_ar) << 2) | (32'(m_up) << 1) | 32'(m_en);
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_count;
      3'd1: return m_pre;
      3'd2: return 32'(m_sts);
      3'd3: return 32'(m_ien);
      3'd4: return m_ctrl_word();
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_clear();
    m_count = 0; m_pre = 0; m_pcnt = 0; m_psc = 0; m_sts = 0; m_ien = 0;
    m_en = 0; m_up = 0; m_ar = 0; m_srst = 0; m_start = 0; m_reload = 0;
    m_halt = 0; m_startd = 0; m_scnt = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_clear();
    else if (m_srst) begin
      if (m_scnt == RSTC - 1) m_clear();
      else m_scnt++;
    end else begin
      bit wr, ld, tk, ev, n_start, n_reload, n_startd, n_sts;
      logic [31:0] n_count, n_pcnt, termv;
      wr = bus_sel && bus_wr;
      n_count = m_count; n_pcnt = m_pcnt; n_start = m_start;
      n_reload = m_reload; n_startd = m_startd; n_sts = m_sts;
      tk = 0; ev = 0;
      ld = m_en && m_start && (!m_startd || m_reload);
      if (m_en) begin
        if (ld) begin n_count = m_pre; n_pcnt = 0; end
        else if (m_start && !m_halt) begin
          if (m_pcnt == m_psc) begin n_pcnt = 0; tk = 1; end
          else n_pcnt = m_pcnt + 1;
        end
        n_startd = m_start;
        n_reload = 0;
      end
      if (tk) begin
        termv = m_up ? MASK : 32'd0;
        if (m_count == termv) begin
          ev = 1;
          if (m_ar) n_count = m_pre; else n_start = 0;
        end else n_count = (m_up ? m_count + 1 : m_count - 1) & MASK;
      end
      if (wr && bus_addr == 3'd2 && bus_wdata[0]) n_sts = 0;
      if (ev) n_sts = 1;
      m_count = n_count; m_pcnt = n_pcnt; m_start = n_start;
      m_reload = n_reload; m_startd = n_startd; m_sts = n_sts;
      if (wr) begin
        case (bus_addr)
          3'd0: m_count = bus_wdata & MASK;
          3'd1: m_pre = bus_wdata & MASK;
          3'd3: m_ien = bus_wdata[0];
          3'd4: begin
            m_psc = 32'(bus_wdata[31:16]);
            m_halt = bus_wdata[6]; m_reload = bus_wdata[5]; m_start = bus_wdata[4];
            m_srst = bus_wdata[3]; m_ar = bus_wdata[2]; m_up = bus_wdata[1]; m_en = bus_wdata[0];
            m_scnt = 0;
          end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      n_tests++;
      if (bus_rdata !== m_read(bus_addr) || irq !== (m_sts && m_ien)) begin
        n_fail++;
        $display("FAIL %s model compare addr=%0d: actual rdata=%h irq=%b expected rdata=%h irq=%b",
                 cur_req, bus_addr, bus_rdata, irq, m_read(bus_addr), m_sts && m_ien);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 32'd0;
  endtask

  task automatic bread(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = 3'd0;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bread(a, v);
    check(req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] c0, v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1 reset values, R13 map
    cur_req = "R1";
    for (int i = 0; i < 5; i++) chk_reg("R1", 3'(i), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    cur_req = "R13";
    chk_reg("R13", 3'd5, 32'd0);
    chk_reg("R13", 3'd7, 32'd0);

    // R12 truncation
    cur_req = "R12";
    bwrite(3'd0, 32'hABCD_1234);
    chk_reg("R12 count trunc", 3'd0, 32'h1234);
    bwrite(3'd1, 32'h7777_0005);
    chk_reg("R12 preload trunc", 3'd1, 32'h0005);

    // R2 / R6 / R3 / R5: down count, prescale 1, no auto-restart
    cur_req = "R2";
    bwrite(3'd4, (32'd1 << 16) | C_EN | C_ST);
    idle(1);
    chk_reg("R6 load on start", 3'd0, 32'd5);
    idle(1);
    chk_reg("R2 no tick yet", 3'd0, 32'd5);
    idle(1);
    chk_reg("R2 first tick", 3'd0, 32'd4);
    cur_req = "R5";
    idle(10);
    chk_reg("R10 status set", 3'd2, 32'd1);
    chk_reg("R3 down terminal", 3'd0, 32'd0);
    chk_reg("R5 start cleared", 3'd4, (32'd1 << 16) | C_EN);
    idle(4);
    chk_reg("R5 count holds", 3'd0, 32'd0);

    // R10 interrupt gating and clear
    cur_req = "R10";
    check("R10 irq masked", 32'(irq), 32'd0);
    bwrite(3'd3, 32'd1);
    check("R10 irq on", 32'(irq), 32'd1);
    bwrite(3'd2, 32'd1);
    chk_reg("R10 w1c", 3'd2, 32'd0);
    check("R10 irq off", 32'(irq), 32'd0);

    // R3 / R4: up count with auto-restart
    cur_req = "R4";
    bwrite(3'd1, 32'h0000_FFFD);
    bwrite(3'd4, C_EN | C_UP | C_AR | C_ST);
    idle(3);
    chk_reg("R3 up to all ones", 3'd0, 32'h0000_FFFF);
    idle(1);
    chk_reg("R4 reloaded", 3'd0, 32'h0000_FFFD);
    chk_reg("R4 start kept", 3'd4, C_EN | C_UP | C_AR | C_ST);
    check("R10 irq raised", 32'(irq), 32'd1);

    // R7 halt
    cur_req = "R7";
    bwrite(3'd4, C_EN | C_UP | C_AR | C_ST | C_HT);
    bread(3'd0, c0);
    idle(5);
    chk_reg("R7 halted", 3'd0, c0);
    bwrite(3'd4, C_EN | C_UP | C_AR | C_ST);
    chk_reg("R7 unhalt edge", 3'd0, c0);
    idle(1);
    chk_reg("R7 resume no reload", 3'd0, (c0 == 32'h0000_FFFF) ? 32'h0000_FFFD : c0 + 1);

    // R6 stop / restart
    cur_req = "R6";
    bwrite(3'd4, C_EN);
    bread(3'd0, c0);
    idle(3);
    chk_reg("R6 stopped holds", 3'd0, c0);
    bwrite(3'd1, 32'd40);
    bwrite(3'd4, C_EN | C_ST);
    idle(1);
    chk_reg("R6 restart loads", 3'd0, 32'd40);
    idle(1);
    chk_reg("R6 counting", 3'd0, 32'd39);

    // R8 reload
    cur_req = "R8";
    bwrite(3'd1, 32'd200);
    bwrite(3'd4, C_EN | C_ST | C_RL);
    idle(1);
    chk_reg("R8 reload taken", 3'd0, 32'd200);
    chk_reg("R8 self clear", 3'd4, C_EN | C_ST);
    bwrite(3'd4, C_EN);
    bread(3'd0, c0);
    bwrite(3'd1, 32'd7);
    bwrite(3'd4, C_EN | C_RL);
    chk_reg("R8 flag stored", 3'd4, C_EN | C_RL);
    idle(1);
    chk_reg("R8 ignored stopped", 3'd0, c0);
    chk_reg("R8 cleared stopped", 3'd4, C_EN);

    // R9 enable freeze
    cur_req = "R9";
    bwrite(3'd4, C_EN | C_ST);
    bwrite(3'd4, C_ST);
    bread(3'd0, c0);
    check("R9 count at freeze", c0, 32'd6);
    idle(6);
    chk_reg("R9 frozen", 3'd0, c0);
    bwrite(3'd4, C_EN | C_ST);
    chk_reg("R9 enable edge", 3'd0, c0);
    idle(1);
    chk_reg("R9 resume", 3'd0, c0 - 1);

    // R11 soft reset
    cur_req = "R11";
    bwrite(3'd4, C_EN | C_ST | C_SR);
    bread(3'd4, v);
    check("R11 bit reads set", v & C_SR, C_SR);
    bwrite(3'd1, 32'd99);
    chk_reg("R11 write ignored", 3'd1, 32'd7);
    idle(8);
    for (int i = 0; i < 5; i++) chk_reg("R11 por value", 3'(i), 32'd0);
    check("R11 irq low", 32'(irq), 32'd0);

    // R12 count write precedence
    cur_req = "R12";
    bwrite(3'd1, 32'h20);
    bwrite(3'd4, C_EN | C_ST);
    idle(2);
    bwrite(3'd0, 32'h1000);
    chk_reg("R12 write wins", 3'd0, 32'h1000);
    idle(1);
    chk_reg("R12 continues", 3'd0, 32'h0FFF);

    idle(2);
    finished = 1;
    summary();
    $finish;
  end

endmodule